// File: doc/BRIEF.md
# Counter-Ramp ADC Conversion Controller

This block sequences a counter-type ramp-compare analog-to-digital conversion. A start request clears an n-bit ramp counter whose value drives an external DAC. The counter climbs by one code per clock. A comparator reports when the DAC voltage has reached the held input, and the block then stops searching. The code that first tripped the comparator is placed on the data output, and a one-clock active-low end-of-conversion strobe is issued. One step is full scale divided by (2^n − 1).

The comparator output is asynchronous, so it passes through two flip-flops before it is used. The block keeps a short record of the codes it has driven, lined up with the synchronizer stages. The result is therefore the exact code that made the comparator trip, even though the ramp overshoots by two codes before the trip is seen. Conversion time rises with the input level: input code T finishes T+3 clocks after the start is taken. If the ramp reaches all ones without a trip, the conversion ends with the full-scale code.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After reset, eoc_n_o is 1, busy_o is 0, data_o is 0 and dac_code_o is 0.
- R2: start_i sampled high at a rising edge while busy_o is 0 begins a conversion: after that edge busy_o is 1 and dac_code_o is 0.
- R3: While busy_o is 1, dac_code_o rises by exactly one per clock until it reaches all ones, where it holds.
- R4: The result on data_o is the smallest code for which cmp_i (1 = DAC at or above input) was high.
- R5: When the result is code T, eoc_n_o goes low after the (T+3)th rising edge following the edge that took the start. This includes two clocks of comparator synchronization.
- R6: If cmp_i never goes high, the conversion ends with data_o all ones, after 2^n+2 edges. This is the same timing as a trip at the all-ones code.
- R7: start_i high while busy_o is 1 has no effect on the result or its timing. This includes a start on the edge where the conversion completes.
- R8: data_o holds its value except at the edge where eoc_n_o goes low.
- R9: eoc_n_o is low for exactly one clock per conversion, and busy_o is 0 during that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled when idle |
| cmp_i | input | 1 | Comparator output, asynchronous; 1 when DAC is at or above the input |
| dac_code_o | output | WIDTH | Ramp code to the DAC |
| data_o | output | WIDTH | Latched conversion result |
| eoc_n_o | output | 1 | End-of-conversion strobe, active low, one clock |
| busy_o | output | 1 | Conversion in progress |

## Verification
Two events can fall on the same edge. The first is a comparator trip and the full-scale limit: a target equal to the all-ones code makes both stop conditions true together. The bench expects all ones at exactly the same latency as a ramp that never trips. The second is a new start request and the completion of a conversion: the bench raises start_i so that it is sampled on the completion edge. It then judges that busy_o stays low, that dac_code_o does not restart, and that no second strobe follows.

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic [WIDTH-1:0] data_o,
  output logic             eoc_n_o,
  output logic             busy_o
);
  localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt, code_d1, code_d2;
  logic             vld_d1, vld_d2;
  logic             cmp_s1, cmp_s2;
  logic             busy, done;

  assign done       = busy && vld_d2 && (cmp_s2 || code_d2 == FULL);
  assign dac_code_o = cnt;
  assign busy_o     = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_s1 <= 1'b0;
      cmp_s2 <= 1'b0;
    end else begin
      cmp_s1 <= cmp_i;
      cmp_s2 <= cmp_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      code_d1 <= '0;
      code_d2 <= '0;
      vld_d1  <= 1'b0;
      vld_d2  <= 1'b0;
      data_o  <= '0;
      eoc_n_o <= 1'b1;
    end else begin
      eoc_n_o <= !done;
      if (done) begin
        data_o <= code_d2;
        busy   <= 1'b0;
      end else if (!busy && start_i) begin
        busy   <= 1'b1;
        cnt    <= '0;
        vld_d1 <= 1'b0;
        vld_d2 <= 1'b0;
      end else if (busy) begin
        if (cnt != FULL) cnt <= cnt + 1'b1;
        code_d1 <= cnt;
        code_d2 <= code_d1;
        vld_d1  <= 1'b1;
        vld_d2  <= vld_d1;
      end
    end
  end
endmodule

module ramp_adc_ctrl_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [WIDTH-1:0] dac_code_o,
  input logic [WIDTH-1:0] data_o,
  input logic             eoc_n_o,
  input logic             busy_o
);
  localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_n_o |=> eoc_n_o);

  a_r9_idle_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_n_o |-> !busy_o);

  a_r3_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && dac_code_o != FULL) |=> (!busy_o || dac_code_o == $past(dac_code_o) + 1'b1));

  a_r3_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && dac_code_o == FULL) |=> (!busy_o || dac_code_o == FULL));

  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_n_o |-> $stable(data_o));

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (!busy_o || dac_code_o != '0));
endmodule

bind ramp_adc_ctrl ramp_adc_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .dac_code_o(dac_code_o),
  .data_o(data_o), .eoc_n_o(eoc_n_o), .busy_o(busy_o)
);

// File: tb/ramp_adc_ctrl_bench.sv
module ramp_adc_ctrl_bench;
  localparam int W    = 8;
  localparam int FULL = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dac, data;
  logic         eoc_n, busy;
  int           target = 1 << 20;
  int           checks = 0;
  int           errors = 0;
  int           cycles = 0;

  wire cmp = (int'(dac) >= target);

  always #4 clk = ~clk;

  ramp_adc_ctrl #(.WIDTH(W)) u_ramp_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp),
    .dac_code_o(dac), .data_o(data), .eoc_n_o(eoc_n), .busy_o(busy)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one conversion; extra_start: edge index (after start edge) at which start is held high, -1 none
  task automatic convert(input int tgt, input int exp_code, input int extra_start);
    int n = 0;
    int prev = int'(data);
    bit ramp_ok = 1'b1;
    bit hold_ok = 1'b1;
    target = tgt;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    check("R2 busy after start", int'(busy), 1);
    check("R2 dac cleared", int'(dac), 0);
    while (eoc_n && n < FULL + 10) begin
      if (n + 1 == extra_start) start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      n++;
      if (eoc_n) begin
        if (busy && int'(dac) != ((n < FULL) ? n : FULL)) ramp_ok = 1'b0;
        if (int'(data) != prev) hold_ok = 1'b0;
      end
    end
    check("R3 ramp one code per clock", int'(ramp_ok), 1);
    check("R8 data held during conversion", int'(hold_ok), 1);
    check("R5 latency", n, ((exp_code < FULL) ? exp_code : FULL) + 3);
    check("R4 result code", int'(data), exp_code);
    check("R9 busy low on strobe", int'(busy), 0);
    @(negedge clk);
    check("R9 strobe one clock", int'(eoc_n), 1);
  endtask

  task automatic t_reset;
    check("R1 eoc idle", int'(eoc_n), 1);
    check("R1 busy idle", int'(busy), 0);
    check("R1 data zero", int'(data), 0);
    check("R1 dac zero", int'(dac), 0);
  endtask

  task automatic t_levels;
    convert(0, 0, -1);
    convert(37, 37, -1);
    convert(200, 200, -1);
    convert(1, 1, -1);
  endtask

  task automatic t_full_scale;
    convert(FULL, FULL, -1);     // R6 trip coincides with all-ones limit
    convert(1 << 20, FULL, -1);  // R6 no trip at all
  endtask

  task automatic t_start_busy;
    convert(50, 50, 10);         // R7 start mid-conversion
    convert(20, 20, 23);         // R7 start on the completion edge
    repeat (3) @(negedge clk);
    check("R7 no restart after completion", int'(busy), 0);
    check("R7 no second strobe", int'(eoc_n), 1);
    check("R8 data unchanged when idle", int'(data), 20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_levels;
    t_full_scale;
    t_start_busy;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule